// File: doc/BRIEF.md
# Two-wire link activation state controller

This block follows the state of a two-wire link between a transceiver and a front-end. One wire carries data into the front-end and the other carries data out of it. The block watches the synchronized level of each wire. It also watches three flags from neighbouring logic: one says a clock is toggling on the outgoing wire, one says a pulse burst was detected on the incoming wire, and one says an information transfer is running. From these it decides whether the link is off, being brought up, up (idle or busy), being shut down, or in command mode.

Bring-up can start from either wire, and each side has its own answer window. When the outgoing wire starts with a clock, the incoming wire must go HIGH within the long window. When the incoming wire starts with a burst, the outgoing clock is accepted only after a minimum delay and before the long window ends. Holding one wire LOW starts a shutdown, and the other wire must then follow it LOW. A burst on the incoming wire while the link is up enters command mode. An external done pulse ends command mode.

All time limits are parameters counted in sampling-clock cycles: the low-hold time (120 µs by default), the minimum answer delay (100 µs) and the answer window (50 ms). The defaults are derived from the sampling-clock frequency. Outputs are the registered state code and four one-cycle event strobes.

Top module: `link_state_ctrl`

## Requirements
- R1: A synchronous reset puts the state in Off and clears all strobes. The state codes are: Off=0, WaitIn=1, WaitOut=2, Idle=3, Busy=4, DrainIn=5, DrainOut=6, Command=7.
- R2: From any state other than Off, when both wires have been LOW for LOW_CYC cycles, the next edge enters Off. This check takes priority over shutdown.
- R3: In Off, an outgoing-clock flag enters WaitIn. In WaitIn, the incoming wire HIGH enters Idle.
- R4: If WaitIn has lasted MAX_CYC cycles without the incoming wire going HIGH, the next edge enters Off.
- R5: In Off, with no outgoing clock, a burst flag enters WaitOut. In WaitOut, an outgoing clock enters Idle once the state has lasted at least MIN_CYC cycles.
- R6: In WaitOut, an outgoing clock that arrives before MIN_CYC cycles sends the state to Off. If no clock arrives within MAX_CYC cycles, the state also goes to Off.
- R7: While the link is up, the state is Busy when the transfer flag is set and Idle when it is clear.
- R8: While the link is up, the outgoing wire held LOW for LOW_CYC cycles enters DrainIn on the next edge. The incoming wire held LOW for LOW_CYC cycles enters DrainOut.
- R9: In DrainIn, the incoming wire going LOW enters Off. In DrainOut, the outgoing wire going LOW enters Off.
- R10: If a Drain state lasts MAX_CYC cycles with no answer, the next edge enters Off and pulses the timeout strobe.
- R11: A burst while the link is up enters Command. Command ignores further bursts and is left to Idle only when the done input is set.
- R12: A strobe pulses for exactly the one cycle after a state change: ev_on on entry to Idle from WaitIn or WaitOut, ev_off on any entry to Off, and ev_cmd on entry to Command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Synchronized level of the incoming (transceiver-driven) wire |
| sig_out | input | 1 | Synchronized level of the outgoing (front-end-driven) wire |
| out_clk_present | input | 1 | A clock is toggling on the outgoing wire |
| in_burst_seen | input | 1 | A pulse burst was detected on the incoming wire |
| xfer_active | input | 1 | An information transfer is running |
| cmd_done | input | 1 | Ends command mode |
| state_o | output | 3 | Registered state code |
| ev_on_o | output | 1 | Link-up strobe |
| ev_off_o | output | 1 | Link-off strobe |
| ev_cmd_o | output | 1 | Command-entry strobe |
| ev_tmo_o | output | 1 | Shutdown-timeout strobe |

## Verification
A flag or wire change that is set up before an edge changes the state code at that edge, and the strobes move at the same edge. A low-hold condition takes LOW_CYC edges to fill its counter, so the state changes one edge after that. A window limit of N cycles counts from the entry edge and takes effect at edge N+1. The bench sets its inputs on the falling edge and samples on a later falling edge, after exactly the number of rising edges that the stimulus needs. It samples at both sides of every limit (LOW_CYC and LOW_CYC+1, MAX_CYC and MAX_CYC+1, and just before and at MIN_CYC), and it checks each strobe in the cycle it is due and again in the cycle after.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [2:0] {
    S_OFF       = 3'd0,
    S_WAIT_IN   = 3'd1,
    S_WAIT_OUT  = 3'd2,
    S_IDLE      = 3'd3,
    S_BUSY      = 3'd4,
    S_DRAIN_IN  = 3'd5,
    S_DRAIN_OUT = 3'd6,
    S_COMMAND   = 3'd7
  } link_state_e;
endpackage

// File: rtl/lsc_low_timer.sv
module lsc_low_timer #(
  parameter int N     = 3,
  parameter int LIMIT = 12000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cond,
  output logic [N-1:0] held
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst || !cond[g]) cnt <= '0;
      else if (cnt != LIM) cnt <= cnt + 1'b1;
    end
    assign held[g] = (cnt == LIM);

    AST_HELD_NEEDS_COND: assert property (@(posedge clk) disable iff (rst)
      $rose(held[g]) |-> $past(cond[g])); // R2
  end
endmodule

// File: rtl/lsc_win_timer.sv
module lsc_win_timer #(
  parameter int MIN_CYC = 10000,
  parameter int MAX_CYC = 5000000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic past_min,
  output logic past_max
);
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] LO = CW'(MIN_CYC);
  localparam logic [CW-1:0] HI = CW'(MAX_CYC);

  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != HI) cnt <= cnt + 1'b1;
  end
  assign past_min = (cnt >= LO);
  assign past_max = (cnt == HI);
endmodule

// File: rtl/lsc_fsm.sv
module lsc_fsm
  import lsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sig_in,
  input  logic        sig_out,
  input  logic        out_clk_present,
  input  logic        in_burst_seen,
  input  logic        xfer_active,
  input  logic        cmd_done,
  input  logic        both_low_held,
  input  logic        out_low_held,
  input  logic        in_low_held,
  input  logic        win_past_min,
  input  logic        win_past_max,
  output logic        win_clr,
  output logic [2:0]  state_o,
  output logic        ev_on_o,
  output logic        ev_off_o,
  output logic        ev_cmd_o,
  output logic        ev_tmo_o
);
  link_state_e st_q, st_d;
  logic        tmo_d;
  logic        ev_on_q, ev_off_q, ev_cmd_q, ev_tmo_q;

  always_comb begin
    st_d  = st_q;
    tmo_d = 1'b0;
    if (st_q != S_OFF && both_low_held) begin
      st_d = S_OFF;
    end else begin
      unique case (st_q)
        S_OFF: begin
          if (out_clk_present)    st_d = S_WAIT_IN;
          else if (in_burst_seen) st_d = S_WAIT_OUT;
        end
        S_WAIT_IN: begin
          if (sig_in)            st_d = S_IDLE;
          else if (win_past_max) st_d = S_OFF;
        end
        S_WAIT_OUT: begin
          if (out_clk_present)   st_d = win_past_min ? S_IDLE : S_OFF;
          else if (win_past_max) st_d = S_OFF;
        end
        S_IDLE, S_BUSY: begin
          if (in_burst_seen)     st_d = S_COMMAND;
          else if (out_low_held) st_d = S_DRAIN_IN;
          else if (in_low_held)  st_d = S_DRAIN_OUT;
          else                   st_d = xfer_active ? S_BUSY : S_IDLE;
        end
        S_DRAIN_IN: begin
          if (!sig_in) st_d = S_OFF;
          else if (win_past_max) begin
            st_d  = S_OFF;
            tmo_d = 1'b1;
          end
        end
        S_DRAIN_OUT: begin
          if (!sig_out) st_d = S_OFF;
          else if (win_past_max) begin
            st_d  = S_OFF;
            tmo_d = 1'b1;
          end
        end
        S_COMMAND: begin
          if (cmd_done) st_d = S_IDLE;
        end
        default: st_d = S_OFF;
      endcase
    end
  end

  assign win_clr = (st_d != st_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_OFF;
      ev_on_q  <= 1'b0;
      ev_off_q <= 1'b0;
      ev_cmd_q <= 1'b0;
      ev_tmo_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      ev_on_q  <= (st_d == S_IDLE) && (st_q == S_WAIT_IN || st_q == S_WAIT_OUT);
      ev_off_q <= (st_d == S_OFF) && (st_q != S_OFF);
      ev_cmd_q <= (st_d == S_COMMAND) && (st_q != S_COMMAND);
      ev_tmo_q <= tmo_d;
    end
  end

  assign state_o  = st_q;
  assign ev_on_o  = ev_on_q;
  assign ev_off_o = ev_off_q;
  assign ev_cmd_o = ev_cmd_q;
  assign ev_tmo_o = ev_tmo_q;

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_on_q, ev_off_q, ev_cmd_q})); // R12
  AST_TMO_LANDS_OFF: assert property (@(posedge clk) disable iff (rst)
    ev_tmo_q |-> (st_q == S_OFF) && ev_off_q); // R10
  AST_CMD_EXIT: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == S_COMMAND && st_q != S_COMMAND) |->
      (st_q == S_IDLE || st_q == S_OFF)); // R11
  AST_ANSWER_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE && $past(st_q) == S_WAIT_OUT) |-> $past(win_past_min)); // R5
  AST_DRAIN_IN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_DRAIN_IN && $past(st_q) != S_DRAIN_IN) |-> $past(out_low_held)); // R8
endmodule

// File: rtl/link_state_ctrl.sv
module link_state_ctrl #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int LOW_CYC = (CLK_HZ / 1_000_000) * 120,
  parameter int MIN_CYC = (CLK_HZ / 1_000_000) * 100,
  parameter int MAX_CYC = (CLK_HZ / 1_000) * 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sig_in,
  input  logic       sig_out,
  input  logic       out_clk_present,
  input  logic       in_burst_seen,
  input  logic       xfer_active,
  input  logic       cmd_done,
  output logic [2:0] state_o,
  output logic       ev_on_o,
  output logic       ev_off_o,
  output logic       ev_cmd_o,
  output logic       ev_tmo_o
);
  localparam int NLANE = 3;

  logic [NLANE-1:0] low_cond, low_held;
  logic             win_clr, win_past_min, win_past_max;

  assign low_cond = {~sig_in & ~sig_out, ~sig_out, ~sig_in};

  lsc_low_timer #(.N(NLANE), .LIMIT(LOW_CYC)) u_low (
    .clk  (clk),
    .rst  (rst),
    .cond (low_cond),
    .held (low_held)
  );

  lsc_win_timer #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)) u_win (
    .clk      (clk),
    .rst      (rst),
    .clr      (win_clr),
    .past_min (win_past_min),
    .past_max (win_past_max)
  );

  lsc_fsm u_fsm (
    .clk             (clk),
    .rst             (rst),
    .sig_in          (sig_in),
    .sig_out         (sig_out),
    .out_clk_present (out_clk_present),
    .in_burst_seen   (in_burst_seen),
    .xfer_active     (xfer_active),
    .cmd_done        (cmd_done),
    .both_low_held   (low_held[2]),
    .out_low_held    (low_held[1]),
    .in_low_held     (low_held[0]),
    .win_past_min    (win_past_min),
    .win_past_max    (win_past_max),
    .win_clr         (win_clr),
    .state_o         (state_o),
    .ev_on_o         (ev_on_o),
    .ev_off_o        (ev_off_o),
    .ev_cmd_o        (ev_cmd_o),
    .ev_tmo_o        (ev_tmo_o)
  );
endmodule

// File: tb/link_state_ctrl_test.sv
module link_state_ctrl_test;
  localparam int LOW = 8;
  localparam int MINC = 5;
  localparam int MAXC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_in = 1'b0, sig_out = 1'b0, clkp = 1'b0, burst = 1'b0, xfer = 1'b0, done = 1'b0;
  logic [2:0] state;
  logic ev_on, ev_off, ev_cmd, ev_tmo;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  link_state_ctrl #(.LOW_CYC(LOW), .MIN_CYC(MINC), .MAX_CYC(MAXC)) uut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .sig_out(sig_out),
    .out_clk_present(clkp), .in_burst_seen(burst), .xfer_active(xfer),
    .cmd_done(done), .state_o(state), .ev_on_o(ev_on), .ev_off_o(ev_off),
    .ev_cmd_o(ev_cmd), .ev_tmo_o(ev_tmo)
  );

  // {req[3:0], in, out, clkp, burst, xfer, done, hold[7:0], exp[2:0]}
  localparam int NV = 17;
  localparam logic [20:0] VEC [NV] = '{
    {4'd3,  6'b011000, 8'd1, 3'd1}, // R3 out clock -> WaitIn
    {4'd3,  6'b111000, 8'd1, 3'd3}, // R3 in HIGH -> Idle
    {4'd7,  6'b111010, 8'd1, 3'd4}, // R7 busy
    {4'd7,  6'b111000, 8'd1, 3'd3}, // R7 back to idle
    {4'd11, 6'b111100, 8'd1, 3'd7}, // R11 burst -> Command
    {4'd11, 6'b111000, 8'd3, 3'd7}, // R11 stays
    {4'd11, 6'b111001, 8'd1, 3'd3}, // R11 done -> Idle
    {4'd8,  6'b100000, 8'd8, 3'd3}, // R8 out LOW, limit not passed
    {4'd8,  6'b100000, 8'd1, 3'd5}, // R8 -> DrainIn
    {4'd9,  6'b000000, 8'd1, 3'd0}, // R9 in LOW -> Off
    {4'd9,  6'b000000, 8'd5, 3'd0}, // R9 stays Off
    {4'd5,  6'b100100, 8'd1, 3'd2}, // R5 burst -> WaitOut
    {4'd5,  6'b100000, 8'd5, 3'd2}, // R5 waiting
    {4'd5,  6'b111000, 8'd1, 3'd3}, // R5 clock at MIN -> Idle
    {4'd8,  6'b011000, 8'd8, 3'd3}, // R8 in LOW, limit not passed
    {4'd8,  6'b011000, 8'd1, 3'd6}, // R8 -> DrainOut
    {4'd9,  6'b000000, 8'd1, 3'd0}  // R9 out LOW -> Off
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    {sig_in, sig_out, clkp, burst, xfer, done} = v;
  endtask

  initial begin
    tick(3);
    chk("R1 reset state", state, 0);
    chk("R1 reset strobes", {ev_on, ev_off, ev_cmd, ev_tmo}, 0);
    rst = 1'b0;
    tick(1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][16:11]);
      tick(int'(VEC[i][10:3]));
      checks++;
      if (state !== VEC[i][2:0]) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual %0d expected %0d", VEC[i][20:17], i, state, VEC[i][2:0]);
      end
    end
    drive(6'b000000);

    // R12 strobes on out-wire bring-up and command entry
    drive(6'b011000); tick(1);
    chk("R12 no on strobe in WaitIn", ev_on, 0);
    drive(6'b111000); tick(1);
    chk("R3 Idle", state, 3);
    chk("R12 ev_on", ev_on, 1);
    tick(1);
    chk("R12 ev_on one cycle", ev_on, 0);
    drive(6'b111100); tick(1);
    chk("R12 ev_cmd", ev_cmd, 1);
    drive(6'b111001); tick(1);
    chk("R12 ev_cmd drops", ev_cmd, 0);
    chk("R11 done -> Idle", state, 3);

    // R2 both LOW beats shutdown
    drive(6'b000000); tick(LOW);
    chk("R2 before limit", state, 3);
    tick(1);
    chk("R2 both LOW -> Off", state, 0);
    chk("R12 ev_off", ev_off, 1);

    // R4 WaitIn timeout
    drive(6'b011000); tick(1);
    chk("R4 WaitIn", state, 1);
    tick(MAXC);
    chk("R4 still waiting at limit", state, 1);
    tick(1);
    chk("R4 timeout -> Off", state, 0);
    drive(6'b000000);

    // R6 early clock in WaitOut
    drive(6'b100100); tick(1);
    chk("R6 WaitOut", state, 2);
    drive(6'b100000); tick(MINC - 1);
    drive(6'b111000); tick(1);
    chk("R6 early clock -> Off", state, 0);
    chk("R12 ev_off early", ev_off, 1);
    drive(6'b100000);

    // R6 no answer in WaitOut
    drive(6'b100100); tick(1);
    drive(6'b100000); tick(MAXC);
    chk("R6 waiting at limit", state, 2);
    tick(1);
    chk("R6 late -> Off", state, 0);

    // R10 shutdown timeout
    drive(6'b111000); tick(2);
    chk("R10 link up", state, 3);
    drive(6'b100000); tick(LOW + 1);
    chk("R10 DrainIn", state, 5);
    tick(MAXC);
    chk("R10 no timeout yet", {state, ev_tmo}, {3'd5, 1'b0});
    tick(1);
    chk("R10 timeout -> Off", state, 0);
    chk("R10 ev_tmo", {ev_tmo, ev_off}, 2'b11);
    tick(1);
    chk("R10 ev_tmo one cycle", ev_tmo, 0);

    // R11 burst ignored in Command; R2 both LOW leaves Command
    drive(6'b111000); tick(2);
    drive(6'b111100); tick(1);
    chk("R11 Command", state, 7);
    tick(1);
    chk("R11 burst ignored", {state, ev_cmd}, {3'd7, 1'b0});
    drive(6'b000000); tick(LOW + 1);
    chk("R2 Command both LOW -> Off", state, 0);

    // R1 reset mid-operation
    drive(6'b011000); tick(1);
    chk("R1 pre-reset WaitIn", state, 1);
    rst = 1'b1; tick(1);
    chk("R1 reset -> Off", {state, ev_on, ev_off, ev_cmd, ev_tmo}, 7'd0);
    drive(6'b000000); rst = 1'b0; tick(2);
    chk("R1 stays Off", state, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule